// File: doc/BRIEF.md
# Single-Error-Correcting Memory Word Codec

This block sits between a processor-side port and a word-wide storage array. When a word is written, the block turns 8 data bits into a 12-bit codeword that holds four extra check bits, and that codeword is what the array stores. When a word is read, the block takes the 12-bit codeword from the array and recomputes the checks. It repairs any single flipped bit and returns the 8 data bits, together with the error syndrome and two status flags.

Each bit of the codeword has a position number from 1 to 12. Check bits sit at positions 1, 2, 4 and 8, and the data bits fill the other positions. Read as an unsigned number, the recomputed syndrome is the position of the bit that is wrong. This is true whether that bit is a data bit or a check bit. The two directions work independently of each other. Each direction registers its result and raises its own valid signal for one cycle, in the cycle after its strobe.

Top module: `hec_codec`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output is cleared to zero. This includes both valid signals, the codeword, the data, the syndrome and both flags.
- R2: Codeword bit `enc_cw[p-1]` holds position p. Data bit `wr_data[7]` goes to position 3, and the remaining bits go in descending order to positions 5, 6, 7, 9, 10, 11 and 12, with `wr_data[0]` at position 12. As a result, data 8'hC4 encodes to 12'h29C.
- R3: Check bit k sits at position 2^k, for k from 0 to 3. Its value gives an even count of ones over every position whose index has bit k set, counting the check bit itself.
- R4: `enc_valid` is high in exactly the cycle after `wr_stb` is high. A new codeword appears in that same cycle. While `wr_stb` is low, `enc_cw` holds its value.
- R5: When a valid codeword is read, the result shows a zero syndrome and both flags low. The data bits are taken from their positions without change.
- R6: When exactly one position p (1 to 12) of a valid codeword is flipped, the result shows `dec_syndrome` equal to p and `dec_corrected` high. The original data is returned. This holds for both data positions and check positions.
- R7: A syndrome of 13, 14 or 15 raises `dec_invalid` and leaves `dec_corrected` low. In that case no bit is flipped, and `dec_data` is taken straight from the received codeword.
- R8: `dec_valid` is high in exactly the cycle after `rd_stb` is high. While `rd_stb` is low, the data, syndrome and flags all hold their values.
- R9: A write and a read that are strobed in the same cycle both complete, and neither affects the other.
- R10: `dec_corrected` and `dec_invalid` are never high together. `dec_corrected` is high only when the syndrome is between 1 and 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Encode request |
| wr_data | input | 8 | Data word to encode |
| enc_cw | output | 12 | Codeword to store, bit p-1 is position p |
| enc_valid | output | 1 | Codeword updated this cycle |
| rd_stb | input | 1 | Decode request |
| rd_cw | input | 12 | Codeword read from storage |
| dec_data | output | 8 | Corrected data word |
| dec_syndrome | output | 4 | Recomputed check result |
| dec_corrected | output | 1 | A single bit was repaired |
| dec_invalid | output | 1 | Syndrome points past position 12 |
| dec_valid | output | 1 | Decode result updated this cycle |

## Verification
The bench flips every one of the 12 positions for several data words, including positions 1, 2, 4 and 8. A design that repaired only data positions, or that used a different position mapping, would return the wrong data or the wrong syndrome. It also corrupts pairs of positions so that the syndrome comes out as 13, 14 or 15. A decoder that indexed past the end of the word, or that flipped a bit anyway, would change the data or set the corrected flag. The bench checks the fixed codeword 12'h29C, which catches a reversed data order or a wrong parity sense. It also checks hold behaviour with the strobes low and while both strobes are applied together, which exposes results that update without a strobe or paths that disturb each other.

// File: rtl/hec_pkg.sv
package hec_pkg;

    localparam int DATA_W = 8;

    function automatic int calc_chk_w(int dw);
        int r;
        r = 0;
        while ((1 << r) < dw + r + 1) r++;
        return r;
    endfunction

    localparam int CHK_W = calc_chk_w(DATA_W);
    localparam int CW_W  = DATA_W + CHK_W;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CW_W-1:0]   cw_t;
    typedef logic [CHK_W-1:0]  syn_t;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_FIXED = 2'd1,
        ERR_BAD   = 2'd2
    } err_kind_t;

    typedef struct packed {
        data_t data;
        syn_t  syn;
        logic  corrected;
        logic  invalid;
    } dec_res_t;

    function automatic logic is_pow2(int p);
        return (p & (p - 1)) == 0;
    endfunction

    // Positions covered by check bit k: every index with bit k set.
    function automatic cw_t cover_mask(int k);
        cw_t m;
        m = '0;
        for (int p = 1; p <= CW_W; p++)
            if (((p >> k) & 1) == 1) m[p-1] = 1'b1;
        return m;
    endfunction

    // Data MSB goes to the lowest non-power-of-two position.
    function automatic cw_t place_data(data_t d);
        cw_t c;
        int  j;
        c = '0;
        j = 0;
        for (int p = 1; p <= CW_W; p++) begin
            if (!is_pow2(p)) begin
                c[p-1] = d[DATA_W-1-j];
                j++;
            end
        end
        return c;
    endfunction

    function automatic data_t extract_data(cw_t c);
        data_t d;
        int    j;
        d = '0;
        j = 0;
        for (int p = 1; p <= CW_W; p++) begin
            if (!is_pow2(p)) begin
                d[DATA_W-1-j] = c[p-1];
                j++;
            end
        end
        return d;
    endfunction

    function automatic syn_t calc_syndrome(cw_t c);
        syn_t s;
        s = '0;
        for (int k = 0; k < CHK_W; k++)
            s[k] = ^(c & cover_mask(k));
        return s;
    endfunction

endpackage

// File: rtl/hec_encoder.sv
module hec_encoder
    import hec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_stb,
    input  data_t wr_data,
    output cw_t   cw_q,
    output logic  valid_q
);

    cw_t        placed;
    logic [CHK_W-1:0] chk;
    cw_t        cw_next;

    always_comb placed = place_data(wr_data);

    for (genvar k = 0; k < CHK_W; k++) begin : g_chk
        localparam cw_t MASK = cover_mask(k);
        assign chk[k] = ^(placed & MASK);
    end

    always_comb begin
        cw_next = placed;
        for (int k = 0; k < CHK_W; k++)
            cw_next[(1 << k) - 1] = chk[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cw_q    <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= wr_stb;
            if (wr_stb) cw_q <= cw_next;
        end
    end

    assert_enc_valid_R4: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> valid_q);
    assert_enc_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> !valid_q && $stable(cw_q));
    assert_enc_parity_R3: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> calc_syndrome(cw_q) == '0);
    assert_enc_layout_R2: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> extract_data(cw_q) == $past(wr_data));

endmodule

// File: rtl/hec_syndrome.sv
module hec_syndrome
    import hec_pkg::*;
(
    input  cw_t  cw,
    output syn_t syn
);

    for (genvar k = 0; k < CHK_W; k++) begin : g_syn
        localparam cw_t MASK = cover_mask(k);
        assign syn[k] = ^(cw & MASK);
    end

endmodule

// File: rtl/hec_corrector.sv
module hec_corrector
    import hec_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     rd_stb,
    input  cw_t      cw,
    input  syn_t     syn,
    output dec_res_t res_q,
    output logic     valid_q
);

    err_kind_t kind;
    cw_t       flip;
    cw_t       fixed_cw;

    always_comb begin
        flip = '0;
        kind = ERR_NONE;
        if (syn != '0) begin
            if (int'(syn) <= CW_W) begin
                kind = ERR_FIXED;
                flip[int'(syn) - 1] = 1'b1;
            end else begin
                kind = ERR_BAD;
            end
        end
        fixed_cw = cw ^ flip;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= rd_stb;
            if (rd_stb) begin
                res_q.data      <= extract_data(fixed_cw);
                res_q.syn       <= syn;
                res_q.corrected <= (kind == ERR_FIXED);
                res_q.invalid   <= (kind == ERR_BAD);
            end
        end
    end

    assert_dec_valid_R8: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> valid_q);
    assert_dec_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> !valid_q && $stable(res_q));
    assert_flag_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(res_q.corrected && res_q.invalid));
    assert_fix_range_R6: assert property (@(posedge clk) disable iff (rst)
        res_q.corrected |-> (res_q.syn != '0) && (int'(res_q.syn) <= CW_W));
    assert_bad_pass_R7: assert property (@(posedge clk) disable iff (rst)
        rd_stb && (int'(syn) > CW_W) |=>
            res_q.invalid && res_q.data == extract_data($past(cw)));
    assert_clean_R5: assert property (@(posedge clk) disable iff (rst)
        rd_stb && syn == '0 |=>
            !res_q.corrected && !res_q.invalid && res_q.data == extract_data($past(cw)));

endmodule

// File: rtl/hec_codec.sv
module hec_codec
    import hec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CW_W-1:0]   enc_cw,
    output logic              enc_valid,
    input  logic              rd_stb,
    input  logic [CW_W-1:0]   rd_cw,
    output logic [DATA_W-1:0] dec_data,
    output logic [CHK_W-1:0]  dec_syndrome,
    output logic              dec_corrected,
    output logic              dec_invalid,
    output logic              dec_valid
);

    syn_t     rd_syn;
    dec_res_t res;

    hec_encoder u_enc (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .cw_q    (enc_cw),
        .valid_q (enc_valid)
    );

    hec_syndrome u_syn (
        .cw  (rd_cw),
        .syn (rd_syn)
    );

    hec_corrector u_cor (
        .clk     (clk),
        .rst     (rst),
        .rd_stb  (rd_stb),
        .cw      (rd_cw),
        .syn     (rd_syn),
        .res_q   (res),
        .valid_q (dec_valid)
    );

    assign dec_data      = res.data;
    assign dec_syndrome  = res.syn;
    assign dec_corrected = res.corrected;
    assign dec_invalid   = res.invalid;

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> !enc_valid && !dec_valid && enc_cw == '0 && dec_data == '0
                && !dec_corrected && !dec_invalid);

endmodule

// File: tb/sim_hec_codec.sv
module sim_hec_codec;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_stb = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [11:0] enc_cw;
    logic        enc_valid;
    logic        rd_stb = 1'b0;
    logic [11:0] rd_cw = '0;
    logic [7:0]  dec_data;
    logic [3:0]  dec_syndrome;
    logic        dec_corrected;
    logic        dec_invalid;
    logic        dec_valid;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    hec_codec u0 (
        .clk(clk), .rst(rst),
        .wr_stb(wr_stb), .wr_data(wr_data), .enc_cw(enc_cw), .enc_valid(enc_valid),
        .rd_stb(rd_stb), .rd_cw(rd_cw), .dec_data(dec_data), .dec_syndrome(dec_syndrome),
        .dec_corrected(dec_corrected), .dec_invalid(dec_invalid), .dec_valid(dec_valid)
    );

    // Reference model written from the position rules.
    function automatic logic [11:0] ref_encode(logic [7:0] d);
        logic [12:1] p;
        p = '0;
        p[3] = d[7]; p[5] = d[6]; p[6] = d[5]; p[7] = d[4];
        p[9] = d[3]; p[10] = d[2]; p[11] = d[1]; p[12] = d[0];
        p[1] = p[3] ^ p[5] ^ p[7] ^ p[9] ^ p[11];
        p[2] = p[3] ^ p[6] ^ p[7] ^ p[10] ^ p[11];
        p[4] = p[5] ^ p[6] ^ p[7] ^ p[12];
        p[8] = p[9] ^ p[10] ^ p[11] ^ p[12];
        return p;
    endfunction

    function automatic logic [7:0] ref_extract(logic [11:0] c);
        return {c[2], c[4], c[5], c[6], c[8], c[9], c[10], c[11]};
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_write(logic [7:0] d);
        @(negedge clk); wr_data = d; wr_stb = 1'b1;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic do_read(logic [11:0] c);
        @(negedge clk); rd_cw = c; rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "enc_valid", enc_valid, 0);
        check("R1", "dec_valid", dec_valid, 0);
        check("R1", "enc_cw", enc_cw, 0);
        check("R1", "dec_data", dec_data, 0);
        check("R1", "flags", {dec_syndrome, dec_corrected, dec_invalid}, 0);
    endtask

    task automatic t_encode_known();
        do_write(8'hC4);
        check("R2", "enc_cw for C4", enc_cw, 12'h29C);
        check("R4", "enc_valid after strobe", enc_valid, 1);
    endtask

    task automatic t_encode_sweep();
        logic [7:0] vals [6] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h01, 8'h80};
        foreach (vals[i]) begin
            do_write(vals[i]);
            check("R3", "enc_cw parity", enc_cw, ref_encode(vals[i]));
        end
    endtask

    task automatic t_clean_read();
        logic [7:0] vals [3] = '{8'h5A, 8'h00, 8'hFF};
        foreach (vals[i]) begin
            do_read(ref_encode(vals[i]));
            check("R5", "clean data", dec_data, vals[i]);
            check("R5", "clean syndrome+flags", {dec_syndrome, dec_corrected, dec_invalid}, 0);
            check("R8", "dec_valid after strobe", dec_valid, 1);
        end
    endtask

    task automatic t_single_errors();
        logic [7:0] vals [3] = '{8'hC4, 8'h96, 8'h0F};
        foreach (vals[i]) begin
            for (int p = 1; p <= 12; p++) begin
                logic [11:0] c;
                c = ref_encode(vals[i]);
                c[p-1] = ~c[p-1];
                do_read(c);
                check("R6", "corrected data", dec_data, vals[i]);
                check("R6", "syndrome = position", dec_syndrome, p);
                check("R10", "corrected/invalid", {dec_corrected, dec_invalid}, 2'b10);
            end
        end
    endtask

    task automatic t_bad_syndrome();
        // Two flips whose indices xor to 13, 14, 15.
        for (int lo = 1; lo <= 3; lo++) begin
            logic [11:0] c;
            c = ref_encode(8'h6B);
            c[11] = ~c[11];
            c[lo-1] = ~c[lo-1];
            do_read(c);
            check("R7", "invalid syndrome value", dec_syndrome, 12 + lo);
            check("R7", "flags", {dec_corrected, dec_invalid}, 2'b01);
            check("R7", "data passed raw", dec_data, ref_extract(c));
        end
    endtask

    task automatic t_hold();
        logic [11:0] cw_before;
        logic [7:0]  d_before;
        cw_before = enc_cw;
        d_before  = dec_data;
        @(negedge clk);
        wr_data = 8'h11; rd_cw = 12'hFFF;
        @(negedge clk);
        @(negedge clk);
        check("R4", "enc_valid low when idle", enc_valid, 0);
        check("R4", "enc_cw held", enc_cw, cw_before);
        check("R8", "dec_valid low when idle", dec_valid, 0);
        check("R8", "dec_data held", dec_data, d_before);
    endtask

    task automatic t_simultaneous();
        logic [11:0] c;
        c = ref_encode(8'hE7);
        c[6] = ~c[6];
        @(negedge clk);
        wr_data = 8'h29; wr_stb = 1'b1;
        rd_cw = c; rd_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0; rd_stb = 1'b0;
        check("R9", "enc_cw concurrent", enc_cw, ref_encode(8'h29));
        check("R9", "dec_data concurrent", dec_data, 8'hE7);
        check("R9", "both valid", {enc_valid, dec_valid}, 2'b11);
        check("R9", "syndrome concurrent", dec_syndrome, 7);
    endtask

    initial begin
        #(20 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_encode_known();
        t_encode_sweep();
        t_clean_read();
        t_single_errors();
        t_bad_syndrome();
        t_hold();
        t_simultaneous();
        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule